// File: doc/BRIEF.md
# Four-Lane Swizzle Move Unit

This block rearranges a short subvector of up to four 32-bit elements, named X, Y, Z and W (lane 0 to 3). The source arrives as a pair of 64-bit words and the result leaves as a pair of 64-bit words. A 12-bit immediate carries one 3-bit selector per destination lane. Each selector copies any source lane into its destination lane, loads a constant zero or one (integer or single-precision float, chosen by a mode input), or skips the lane so that it keeps its earlier contents.

Source and destination subvector lengths are given separately, from 1 to 4. A three-element source can therefore feed a two-element destination. The destination pair is held in the block's own output register. Every enabled lane of both 64-bit halves is written on one clock edge, so no half-updated pair can ever be observed. Register pair numbers must be even. An odd pair number, a bad length or a reserved selector rejects the whole operation. The block then raises a flag and writes nothing.

Top module: `swz_move_unit`

## Requirements
- R1: Selector bits [3i+2:3i] of `sel_imm` control destination lane i. A selector of 0b1NN copies source lane NN into lane i. Lanes are placed as follows: X = low word [31:0], Y = low word [63:32], Z = high word [31:0], W = high word [63:32], in both the source and the destination pairs.
- R2: Selector 0b000 skips the lane. Its bit in `wr_mask` is 0 and its destination value keeps its earlier contents.
- R3: Selector 0b010 writes 0x00000000. Selector 0b011 writes 0x00000001 when `float_mode`=0 and 0x3F800000 when `float_mode`=1.
- R4: Selector 0b001 is reserved. On any lane below the destination length it sets `bad_sel`=1 and `wr_mask`=0, and no lane changes. On a lane at or beyond the destination length it has no effect.
- R5: A copy selector whose index NN is at or beyond `src_len` writes zero.
- R6: Destination lanes at or beyond `dst_len` are never written, whatever their selector is.
- R7: An odd `src_pair` or `dst_pair`, or a `src_len` or `dst_len` outside 1..4, sets `bad_regs`=1 and `wr_mask`=0, and no lane changes.
- R8: `done`, `wr_mask` and the two flags appear on the first rising edge after `in_valid` and last one cycle. While `done` is 0 they are all 0. `wr_mask` bit i is lane i, and bits 7:4 are always 0.
- R9: All enabled lanes of both destination halves update on the same clock edge.
- R10: While `rst_n` is low at a rising edge, `dst_lo`, `dst_hi`, `wr_mask`, `done`, `bad_sel` and `bad_regs` are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe: operation inputs are valid this cycle |
| float_mode | input | 1 | 1 selects float constants, 0 selects integer constants |
| sel_imm | input | 12 | Four 3-bit lane selectors, lane 0 in the low bits |
| src_len | input | 3 | Source subvector length, 1..4 |
| dst_len | input | 3 | Destination subvector length, 1..4 |
| src_pair | input | 5 | Source register pair number, must be even |
| dst_pair | input | 5 | Destination register pair number, must be even |
| src_lo | input | 64 | Source lanes Y:X |
| src_hi | input | 64 | Source lanes W:Z |
| dst_lo | output | 64 | Destination lanes Y:X |
| dst_hi | output | 64 | Destination lanes W:Z |
| wr_mask | output | 8 | Per-lane write enables of this commit (low 4 bits used) |
| done | output | 1 | One-cycle pulse marking a commit |
| bad_sel | output | 1 | Reserved selector seen on an active lane |
| bad_regs | output | 1 | Odd pair number or illegal length |

## Verification
Every result sits exactly one register stage behind its strobe. `dst_lo`, `dst_hi`, `wr_mask`, `done` and both flags are due on the first rising edge after `in_valid` is sampled high. The bench raises `in_valid` on a falling edge and lowers it on the next falling edge. It samples all outputs at that same falling edge, half a period after the commit edge, and samples once more a cycle later to confirm that `done`, the mask and the flags have returned to zero. Because each scenario builds on a destination state the bench set up itself, any lane that must be held (skip, rejected operations, lanes beyond the length) is compared against that known earlier value.

// File: rtl/swz_pkg.sv
// Package: shared selector encoding and constants for the swizzle move unit.
// Assumes 3-bit selectors: the top bit marks a lane copy, the low two bits
// pick the source lane (copy) or a fixed action (no copy).
package swz_pkg;

    localparam int SEL_W = 3;
    localparam int IDX_W = 2;

    // Fixed-action codes held in the low bits when the copy bit is clear.
    localparam logic [IDX_W-1:0] CODE_SKIP = 2'd0;
    localparam logic [IDX_W-1:0] CODE_RSVD = 2'd1;
    localparam logic [IDX_W-1:0] CODE_ZERO = 2'd2;
    localparam logic [IDX_W-1:0] CODE_ONE  = 2'd3;

    // Single-precision bit pattern of 1.0.
    localparam logic [31:0] FP32_ONE = 32'h3F80_0000;

    typedef enum logic [2:0] {
        K_SKIP,
        K_RSVD,
        K_ZERO,
        K_ONE,
        K_COPY
    } sel_kind_e;

    // Map a raw selector onto the action it requests.
    function automatic sel_kind_e sel_classify(input logic [SEL_W-1:0] sel);
        sel_kind_e k;
        if (sel[SEL_W-1]) begin
            k = K_COPY;
        end else begin
            case (sel[IDX_W-1:0])
                CODE_SKIP: k = K_SKIP;
                CODE_RSVD: k = K_RSVD;
                CODE_ZERO: k = K_ZERO;
                default:   k = K_ONE;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/swz_lane.sv
// Module: swz_lane
// Decodes one destination lane: works out whether the lane is written and
// with what value (source copy, zero, or integer/float one). Assumes the lane
// number LANE_ID is below LANES and that LANES is at most 4.
module swz_lane #(
    parameter int LANES   = 4,
    parameter int ELEM_W  = 32,
    parameter int LANE_ID = 0,
    parameter int LEN_W   = 3
) (
    input  logic [swz_pkg::SEL_W-1:0] sel,
    input  logic                      float_mode,
    input  logic [LEN_W-1:0]          src_len,
    input  logic [LEN_W-1:0]          dst_len,
    input  logic [LANES*ELEM_W-1:0]   src_flat,
    output logic                      we,
    output logic [ELEM_W-1:0]         data,
    output logic                      rsvd_hit
);
    import swz_pkg::*;

    localparam logic [ELEM_W-1:0] INT_ONE = ELEM_W'(1);
    localparam logic [ELEM_W-1:0] FLT_ONE = ELEM_W'(FP32_ONE);

    sel_kind_e           kind;
    logic                in_dst;
    logic [IDX_W-1:0]    idx;
    logic                idx_ok;
    logic [ELEM_W-1:0]   picked;

    // Classify the selector and check the lane against the destination length.
    always_comb begin
        kind   = sel_classify(sel);
        in_dst = LEN_W'(LANE_ID) < dst_len;
        idx    = sel[IDX_W-1:0];
        idx_ok = LEN_W'(idx) < src_len;
    end

    // Pick the addressed source lane; an index past the source length reads zero.
    always_comb begin
        picked = '0;
        for (int k = 0; k < LANES; k++) begin
            if (idx == IDX_W'(k) && idx_ok) begin
                picked = src_flat[k*ELEM_W +: ELEM_W];
            end
        end
    end

    // Produce the lane value, its write enable and the reserved-code flag.
    always_comb begin
        we       = 1'b0;
        data     = '0;
        rsvd_hit = 1'b0;
        case (kind)
            K_COPY: begin
                we   = in_dst;
                data = picked;
            end
            K_ZERO: begin
                we   = in_dst;
                data = '0;
            end
            K_ONE: begin
                we   = in_dst;
                data = float_mode ? FLT_ONE : INT_ONE;
            end
            K_RSVD: begin
                rsvd_hit = in_dst;
            end
            default: begin
                we = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/swz_guard.sv
// Module: swz_guard
// Legality check for one operation: even register pair numbers, lengths in
// 1..LANES, and no reserved selector on an active lane. Purely combinational.
module swz_guard #(
    parameter int LANES     = 4,
    parameter int LEN_W     = 3,
    parameter int REG_IDX_W = 5
) (
    input  logic [REG_IDX_W-1:0] src_pair,
    input  logic [REG_IDX_W-1:0] dst_pair,
    input  logic [LEN_W-1:0]     src_len,
    input  logic [LEN_W-1:0]     dst_len,
    input  logic [LANES-1:0]     rsvd_hits,
    output logic                 bad_regs,
    output logic                 bad_sel,
    output logic                 commit_ok
);
    localparam logic [REG_IDX_W-1:0] ODD_BIT = REG_IDX_W'(1);
    localparam logic [LEN_W-1:0]     MAX_LEN = LEN_W'(LANES);

    // True when a length lies inside the supported range.
    function automatic logic len_legal(input logic [LEN_W-1:0] len);
        return (len != '0) && (len <= MAX_LEN);
    endfunction

    // Combine pair alignment, length range and selector checks.
    always_comb begin
        bad_regs  = ((src_pair & ODD_BIT) != '0) ||
                    ((dst_pair & ODD_BIT) != '0) ||
                    !len_legal(src_len) ||
                    !len_legal(dst_len);
        bad_sel   = |rsvd_hits;
        commit_ok = !bad_regs && !bad_sel;
    end

endmodule

// File: rtl/swz_commit.sv
// Module: swz_commit
// Destination pair register. On a strobe that passed the legality check it
// writes every enabled lane on one edge; skipped lanes hold. Also registers
// the done pulse, write mask and error flags. Synchronous active-low reset.
module swz_commit #(
    parameter int LANES  = 4,
    parameter int ELEM_W = 32,
    parameter int MASK_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    commit_ok,
    input  logic                    bad_sel_in,
    input  logic                    bad_regs_in,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*ELEM_W-1:0] lane_data,
    output logic [LANES*ELEM_W-1:0] dst_flat,
    output logic [MASK_W-1:0]       wr_mask,
    output logic                    done,
    output logic                    bad_sel,
    output logic                    bad_regs
);
    logic do_commit;

    // A commit needs a strobe and a legal operation.
    always_comb begin
        do_commit = in_valid && commit_ok;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane_reg
        // Lane storage: load on an enabled commit, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dst_flat[g*ELEM_W +: ELEM_W] <= '0;
            end else if (do_commit && lane_we[g]) begin
                dst_flat[g*ELEM_W +: ELEM_W] <= lane_data[g*ELEM_W +: ELEM_W];
            end
        end
    end

    // Status pulse: done, mask and flags live for one cycle after a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            wr_mask  <= '0;
            bad_sel  <= 1'b0;
            bad_regs <= 1'b0;
        end else begin
            done     <= in_valid;
            wr_mask  <= do_commit ? MASK_W'(lane_we) : '0;
            bad_sel  <= in_valid && bad_sel_in;
            bad_regs <= in_valid && bad_regs_in;
        end
    end

endmodule

// File: rtl/swz_move_unit.sv
// Module: swz_move_unit (top)
// Four-lane swizzle move: per-lane selector decode, constant insertion,
// skip masking and an all-at-once update of a 64-bit destination pair.
// Assumes LANES <= 4 and a mask at least LANES bits wide.
module swz_move_unit #(
    parameter int LANES     = 4,
    parameter int ELEM_W    = 32,
    parameter int REG_IDX_W = 5,
    parameter int MASK_W    = 8,
    localparam int SEL_W    = swz_pkg::SEL_W,
    localparam int LEN_W    = $clog2(LANES + 1),
    localparam int PAIR_W   = LANES * ELEM_W / 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   float_mode,
    input  logic [LANES*SEL_W-1:0] sel_imm,
    input  logic [LEN_W-1:0]       src_len,
    input  logic [LEN_W-1:0]       dst_len,
    input  logic [REG_IDX_W-1:0]   src_pair,
    input  logic [REG_IDX_W-1:0]   dst_pair,
    input  logic [PAIR_W-1:0]      src_lo,
    input  logic [PAIR_W-1:0]      src_hi,
    output logic [PAIR_W-1:0]      dst_lo,
    output logic [PAIR_W-1:0]      dst_hi,
    output logic [MASK_W-1:0]      wr_mask,
    output logic                   done,
    output logic                   bad_sel,
    output logic                   bad_regs
);
    logic [LANES*ELEM_W-1:0] src_flat;
    logic [LANES*ELEM_W-1:0] lane_data;
    logic [LANES*ELEM_W-1:0] dst_flat;
    logic [LANES-1:0]        lane_we;
    logic [LANES-1:0]        rsvd_hits;
    logic                    comb_bad_regs;
    logic                    comb_bad_sel;
    logic                    commit_ok;

    // Pack the source pair into lane order X,Y,Z,W from the bottom up.
    always_comb begin
        src_flat = {src_hi, src_lo};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        swz_lane #(
            .LANES  (LANES),
            .ELEM_W (ELEM_W),
            .LANE_ID(g),
            .LEN_W  (LEN_W)
        ) u_lane (
            .sel       (sel_imm[g*SEL_W +: SEL_W]),
            .float_mode(float_mode),
            .src_len   (src_len),
            .dst_len   (dst_len),
            .src_flat  (src_flat),
            .we        (lane_we[g]),
            .data      (lane_data[g*ELEM_W +: ELEM_W]),
            .rsvd_hit  (rsvd_hits[g])
        );
    end

    swz_guard #(
        .LANES    (LANES),
        .LEN_W    (LEN_W),
        .REG_IDX_W(REG_IDX_W)
    ) u_guard (
        .src_pair (src_pair),
        .dst_pair (dst_pair),
        .src_len  (src_len),
        .dst_len  (dst_len),
        .rsvd_hits(rsvd_hits),
        .bad_regs (comb_bad_regs),
        .bad_sel  (comb_bad_sel),
        .commit_ok(commit_ok)
    );

    swz_commit #(
        .LANES (LANES),
        .ELEM_W(ELEM_W),
        .MASK_W(MASK_W)
    ) u_commit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .commit_ok  (commit_ok),
        .bad_sel_in (comb_bad_sel),
        .bad_regs_in(comb_bad_regs),
        .lane_we    (lane_we),
        .lane_data  (lane_data),
        .dst_flat   (dst_flat),
        .wr_mask    (wr_mask),
        .done       (done),
        .bad_sel    (bad_sel),
        .bad_regs   (bad_regs)
    );

    // Split the destination register back into its two 64-bit halves.
    always_comb begin
        dst_lo = dst_flat[PAIR_W-1:0];
        dst_hi = dst_flat[2*PAIR_W-1:PAIR_W];
    end

endmodule

// File: rtl/swz_move_chk.sv
// Module: swz_move_chk
// Property checker for swz_move_unit, attached with bind below. Observes
// ports only. Assumes the default LANES=4 / ELEM_W=32 lane layout.
module swz_move_chk #(
    parameter int LANES  = 4,
    parameter int ELEM_W = 32,
    parameter int MASK_W = 8,
    parameter int LEN_W  = 3,
    parameter int SEL_W  = 3,
    parameter int PAIR_W = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   float_mode,
    input logic [LANES*SEL_W-1:0] sel_imm,
    input logic [LEN_W-1:0]       dst_len,
    input logic [PAIR_W-1:0]      dst_lo,
    input logic [PAIR_W-1:0]      dst_hi,
    input logic [MASK_W-1:0]      wr_mask,
    input logic                   done,
    input logic                   bad_sel,
    input logic                   bad_regs
);
    logic [LANES*ELEM_W-1:0] dst_all;

    // Lanes that a given destination length allows to be written.
    function automatic logic [LANES-1:0] allowed(input logic [LEN_W-1:0] len);
        logic [LANES-1:0] m;
        for (int k = 0; k < LANES; k++) begin
            m[k] = LEN_W'(k) < len;
        end
        return m;
    endfunction

    // Rebuild the full destination in lane order.
    always_comb begin
        dst_all = {dst_hi, dst_lo};
    end

    AST_DONE_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done); // R8

    AST_NO_DONE_WITHOUT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !done); // R8

    AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (wr_mask == '0 && !bad_sel && !bad_regs)); // R8

    AST_MASK_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask[MASK_W-1:LANES] == '0); // R8

    AST_SEL_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_sel |-> wr_mask == '0); // R4

    AST_REG_ERR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bad_regs |-> wr_mask == '0); // R7

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (wr_mask[LANES-1:0] & ~allowed($past(dst_len))) == '0); // R6

    AST_FLOAT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && wr_mask[0] && $past(float_mode) && $past(sel_imm[2:0]) == 3'b011)
        |-> dst_lo[31:0] == 32'h3F80_0000); // R3

    for (genvar g = 0; g < LANES; g++) begin : g_hold
        AST_UNMASKED_LANE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_mask[g] |-> $stable(dst_all[g*ELEM_W +: ELEM_W])); // R2
    end

endmodule

bind swz_move_unit swz_move_chk #(
    .LANES (LANES),
    .ELEM_W(ELEM_W),
    .MASK_W(MASK_W),
    .LEN_W (LEN_W),
    .SEL_W (SEL_W),
    .PAIR_W(PAIR_W)
) u_swz_move_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .float_mode(float_mode),
    .sel_imm   (sel_imm),
    .dst_len   (dst_len),
    .dst_lo    (dst_lo),
    .dst_hi    (dst_hi),
    .wr_mask   (wr_mask),
    .done      (done),
    .bad_sel   (bad_sel),
    .bad_regs  (bad_regs)
);

// File: tb/test_swz_move_unit.sv
// Directed bench for swz_move_unit: one task per scenario, each checking
// its own results half a period after the commit edge.
module test_swz_move_unit;

    localparam logic [31:0] LX = 32'hAAAA_0000;
    localparam logic [31:0] LY = 32'hBBBB_1111;
    localparam logic [31:0] LZ = 32'hCCCC_2222;
    localparam logic [31:0] LW = 32'hDDDD_3333;
    localparam logic [31:0] F1 = 32'h3F80_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        float_mode = 1'b0;
    logic [11:0] sel_imm = '0;
    logic [2:0]  src_len = 3'd4;
    logic [2:0]  dst_len = 3'd4;
    logic [4:0]  src_pair = '0;
    logic [4:0]  dst_pair = '0;
    logic [63:0] src_lo = {LY, LX};
    logic [63:0] src_hi = {LW, LZ};
    logic [63:0] dst_lo;
    logic [63:0] dst_hi;
    logic [7:0]  wr_mask;
    logic        done;
    logic        bad_sel;
    logic        bad_regs;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    swz_move_unit i_swz_move_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .float_mode(float_mode),
        .sel_imm   (sel_imm),
        .src_len   (src_len),
        .dst_len   (dst_len),
        .src_pair  (src_pair),
        .dst_pair  (dst_pair),
        .src_lo    (src_lo),
        .src_hi    (src_hi),
        .dst_lo    (dst_lo),
        .dst_hi    (dst_hi),
        .wr_mask   (wr_mask),
        .done      (done),
        .bad_sel   (bad_sel),
        .bad_regs  (bad_regs)
    );

    function automatic logic [11:0] s4(input logic [2:0] x, input logic [2:0] y,
                                       input logic [2:0] z, input logic [2:0] w);
        return {w, z, y, x};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Drive one strobe; returns at the falling edge after the commit edge.
    task automatic run_op(input logic [11:0] sel, input logic [2:0] sl, input logic [2:0] dl,
                          input logic fm, input logic [4:0] sp, input logic [4:0] dp);
        @(negedge clk);
        sel_imm    = sel;
        src_len    = sl;
        dst_len    = dl;
        float_mode = fm;
        src_pair   = sp;
        dst_pair   = dp;
        in_valid   = 1'b1;
        @(negedge clk);
        in_valid   = 1'b0;
    endtask

    // Full-status check right after a commit.
    task automatic chk_commit(input string tag, input logic [63:0] lo, input logic [63:0] hi,
                              input logic [7:0] m, input logic bs, input logic br);
        chk({tag, " dst_lo"}, dst_lo, lo);
        chk({tag, " dst_hi"}, dst_hi, hi);
        chk({tag, " wr_mask"}, 64'(wr_mask), 64'(m));
        chk({tag, " done"}, 64'(done), 64'd1);
        chk({tag, " bad_sel"}, 64'(bad_sel), 64'(bs));
        chk({tag, " bad_regs"}, 64'(bad_regs), 64'(br));
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R10 reset dst_lo", dst_lo, 64'd0);
        chk("R10 reset dst_hi", dst_hi, 64'd0);
        chk("R10 reset status", {done, bad_sel, bad_regs, wr_mask}, 64'd0);
        rst_n = 1'b1;
    endtask

    task automatic t_permute;
        run_op(s4(3'b111, 3'b110, 3'b101, 3'b100), 3'd4, 3'd4, 1'b0, 5'd2, 5'd4);
        chk_commit("R1 R9 reverse", {LZ, LW}, {LX, LY}, 8'h0F, 1'b0, 1'b0);
        @(negedge clk);
        chk("R8 done pulse ends", 64'(done), 64'd0);
        chk("R8 mask clears", 64'(wr_mask), 64'd0);
        chk("R8 value held", {dst_hi[31:0], dst_lo[31:0]}, {LY, LW});
    endtask

    task automatic t_skip;
        run_op(s4(3'b111, 3'b000, 3'b101, 3'b000), 3'd4, 3'd4, 1'b0, 5'd0, 5'd0);
        chk_commit("R2 skip Y W", {LZ, LW}, {LX, LY}, 8'h05, 1'b0, 1'b0);
        run_op(s4(3'b100, 3'b100, 3'b100, 3'b100), 3'd4, 3'd4, 1'b0, 5'd0, 5'd0);
        chk_commit("R1 broadcast X", {LX, LX}, {LX, LX}, 8'h0F, 1'b0, 1'b0);
    endtask

    task automatic t_consts;
        run_op(s4(3'b010, 3'b011, 3'b011, 3'b010), 3'd4, 3'd4, 1'b0, 5'd0, 5'd0);
        chk_commit("R3 int consts", {32'd1, 32'd0}, {32'd0, 32'd1}, 8'h0F, 1'b0, 1'b0);
        run_op(s4(3'b010, 3'b011, 3'b011, 3'b010), 3'd4, 3'd4, 1'b1, 5'd0, 5'd0);
        chk_commit("R3 float consts", {F1, 32'd0}, {32'd0, F1}, 8'h0F, 1'b0, 1'b0);
    endtask

    task automatic t_reserved;
        run_op(s4(3'b100, 3'b001, 3'b100, 3'b100), 3'd4, 3'd4, 1'b0, 5'd0, 5'd0);
        chk_commit("R4 reserved rejects", {F1, 32'd0}, {32'd0, F1}, 8'h00, 1'b1, 1'b0);
        run_op(s4(3'b101, 3'b100, 3'b000, 3'b001), 3'd4, 3'd2, 1'b0, 5'd0, 5'd0);
        chk_commit("R4 R6 reserved past length", {LX, LY}, {32'd0, F1}, 8'h03, 1'b0, 1'b0);
    endtask

    task automatic t_src_len;
        // vec3 source to vec2 destination: W is beyond the source, Z is inside
        run_op(s4(3'b111, 3'b110, 3'b100, 3'b100), 3'd3, 3'd2, 1'b0, 5'd6, 5'd8);
        chk_commit("R5 index past source", {LZ, 32'd0}, {32'd0, F1}, 8'h03, 1'b0, 1'b0);
    endtask

    task automatic t_dst_len;
        run_op(s4(3'b111, 3'b111, 3'b111, 3'b111), 3'd4, 3'd1, 1'b0, 5'd0, 5'd0);
        chk_commit("R6 length one", {LZ, LW}, {32'd0, F1}, 8'h01, 1'b0, 1'b0);
    endtask

    task automatic t_bad_regs;
        run_op(s4(3'b100, 3'b101, 3'b110, 3'b111), 3'd4, 3'd4, 1'b0, 5'd3, 5'd0);
        chk_commit("R7 odd source pair", {LZ, LW}, {32'd0, F1}, 8'h00, 1'b0, 1'b1);
        run_op(s4(3'b100, 3'b101, 3'b110, 3'b111), 3'd4, 3'd4, 1'b0, 5'd0, 5'd5);
        chk_commit("R7 odd dest pair", {LZ, LW}, {32'd0, F1}, 8'h00, 1'b0, 1'b1);
        run_op(s4(3'b100, 3'b101, 3'b110, 3'b111), 3'd4, 3'd0, 1'b0, 5'd0, 5'd0);
        chk_commit("R7 zero dest length", {LZ, LW}, {32'd0, F1}, 8'h00, 1'b0, 1'b1);
        run_op(s4(3'b100, 3'b101, 3'b110, 3'b111), 3'd5, 3'd4, 1'b0, 5'd0, 5'd0);
        chk_commit("R7 source length five", {LZ, LW}, {32'd0, F1}, 8'h00, 1'b0, 1'b1);
        @(negedge clk);
        chk("R8 flags clear", {done, bad_sel, bad_regs, wr_mask}, 64'd0);
    endtask

    task automatic t_back_to_back;
        // Two strobes on consecutive cycles: each commits on its own edge.
        @(negedge clk);
        sel_imm = s4(3'b100, 3'b101, 3'b110, 3'b111);
        src_len = 3'd4; dst_len = 3'd4; float_mode = 1'b0;
        src_pair = '0; dst_pair = '0; in_valid = 1'b1;
        @(negedge clk);
        chk_commit("R8 R9 first of pair", {LY, LX}, {LW, LZ}, 8'h0F, 1'b0, 1'b0);
        sel_imm = s4(3'b000, 3'b000, 3'b010, 3'b010);
        @(negedge clk);
        in_valid = 1'b0;
        chk_commit("R8 R2 second of pair", {LY, LX}, {32'd0, 32'd0}, 8'h0C, 1'b0, 1'b0);
        @(negedge clk);
        chk("R8 idle after pair", 64'(done), 64'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        t_reset();
        t_permute();
        t_skip();
        t_consts();
        t_reserved();
        t_src_len();
        t_dst_len();
        t_bad_regs();
        t_back_to_back();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule